// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox

This block lets a system controller and an application processor signal each other through doorbell registers. Each processor has its own register port. There are `NCH` priority channels in each direction, with channel 0 the low-priority one and channel 1 the high-priority one. Each channel has three registers:

- a status register holding the pending doorbell bits;
- a set register that raises bits in status;
- a clear register that drops bits from status.

While a channel's status is nonzero, a level interrupt is raised towards the receiving processor. The sender writes a command word to the set register. The receiver reads the status, handles the message and writes all ones to the clear register. The sender then sees zero when it reads the same status back, which marks the transfer complete.

Message bodies go into a shared payload window, backed by an on-chip RAM that both ports can reach. Reset clears every status register and every interrupt. The payload RAM is not initialised.

Top module: `mbx_doorbell`

## Requirements
- R1: After reset every status register reads zero, both interrupt vectors are low and no read response is pending.
- R2: Register map, identical on both ports, with byte addresses, bits 11:9 zero and bits 2:0 zero:
  - bit 8 selects the bank: 0 carries messages towards the application processor, 1 carries them towards the controller;
  - bits 7:5 give the channel;
  - bits 4:3 give the register: 0 status, 1 set, 2 clear.
  
  A write to a set register ORs the written data into that channel's status.
- R3: A write to a clear register removes the written one-bits from that channel's status. Writing all ones brings status to zero.
- R4: When a set and a clear reach the same status in the same cycle, from either port or both, a bit present in both stays set.
- R5: `irq_to_ap[c]` is high exactly while bank 0 channel c status is nonzero, and `irq_to_sc[c]` while bank 1 channel c status is nonzero. Each changes in the cycle after the write that changes the status.
- R6: Reads of set registers, clear registers, channels at or above `NCH` and other unmapped addresses return zero. Writes to status registers and unmapped addresses change nothing.
- R7: A read request (valid high, write low) produces `rvalid` with data in the next cycle. The data is the value held before any write accepted in the same cycle.
- R8: Addresses with bit 11 set and bits 1:0 zero map to a payload RAM word, at word index bits 10:2. Reception data for channel c sits at byte c·0x400 and transmission data at c·0x400+0x200. A word written from either port reads back from both ports.
- R9: If both ports write the same payload word in one cycle, the controller port's data is kept.
- R10: A doorbell write affects only the addressed bank and channel. Every other status register and interrupt is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc_valid | input | 1 | Controller port request |
| sc_write | input | 1 | Controller port write (1) or read (0) |
| sc_addr | input | ADDR_W | Controller port byte address |
| sc_wdata | input | DATA_W | Controller port write data |
| sc_rvalid | output | 1 | Controller port read response valid |
| sc_rdata | output | DATA_W | Controller port read data |
| ap_valid | input | 1 | Application port request |
| ap_write | input | 1 | Application port write (1) or read (0) |
| ap_addr | input | ADDR_W | Application port byte address |
| ap_wdata | input | DATA_W | Application port write data |
| ap_rvalid | output | 1 | Application port read response valid |
| ap_rdata | output | DATA_W | Application port read data |
| irq_to_ap | output | NCH | Per-channel interrupt to the application processor |
| irq_to_sc | output | NCH | Per-channel interrupt to the controller |

## Verification
The hardest situation to reach is two ports acting on the same state in one cycle. One case is a set from one side meeting a clear from the other on the same status word. The other is both sides writing the same payload word. Independent random streams rarely line up on one address. The random stimulus therefore draws register addresses from a small set of banks and channels, and payload addresses from sixteen words, so collisions happen often. Directed steps also force each collision explicitly, along with a read issued in the cycle of a write to the same status.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STAT,
        ACC_SET,
        ACC_CLR,
        ACC_PAY
    } acc_kind_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 2
) (
    input  logic [ADDR_W-1:0]        addr,
    output acc_kind_t                kind,
    output logic                     bank,
    output logic [2:0]               ch,
    output logic [$clog2(NCH*256)-1:0] word
);
    localparam int PAY_AW  = $clog2(NCH * 1024);
    localparam int PAY_SEL = 1 << (ADDR_W - 1 - PAY_AW);

    always_comb begin
        kind = ACC_NONE;
        bank = addr[8];
        ch   = addr[7:5];
        word = addr[PAY_AW-1:2];
        if ((addr >> PAY_AW) == ADDR_W'(PAY_SEL)) begin
            if (addr[1:0] == 2'b00) kind = ACC_PAY;
        end else if ((addr >> 9) == '0 && addr[2:0] == 3'b000 && int'(addr[7:5]) < NCH) begin
            case (addr[4:3])
                2'd0:    kind = ACC_STAT;
                2'd1:    kind = ACC_SET;
                2'd2:    kind = ACC_CLR;
                default: kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/mbx_status_bank.sv
module mbx_status_bank #(
    parameter int NST    = 4,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NST-1:0][DATA_W-1:0]    set_m,
    input  logic [NST-1:0][DATA_W-1:0]    clr_m,
    output logic [NST-1:0][DATA_W-1:0]    st_q
);
    typedef struct packed {
        logic [NST-1:0][DATA_W-1:0] st;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NST; i++) begin
            // set is applied after clear so it dominates
            bank_d.st[i] = (bank_q.st[i] & ~clr_m[i]) | set_m[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign st_q = bank_q.st;
endmodule

// File: rtl/mbx_payload_ram.sv
module mbx_payload_ram #(
    parameter int WORDS  = 512,
    parameter int DATA_W = 32,
    parameter int NPORT  = 2
) (
    input  logic                                  clk,
    input  logic [NPORT-1:0]                      en,
    input  logic [NPORT-1:0]                      we,
    input  logic [NPORT-1:0][$clog2(WORDS)-1:0]   addr,
    input  logic [NPORT-1:0][DATA_W-1:0]          wdata,
    output logic [NPORT-1:0][DATA_W-1:0]          rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    // lower port index is written last and so wins a same-word collision
    always_ff @(posedge clk) begin
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (en[p]) begin
                rdata[p] <= mem[addr[p]];
                if (we[p]) mem[addr[p]] <= wdata[p];
            end
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_valid,
    input  logic              sc_write,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [DATA_W-1:0] sc_wdata,
    output logic              sc_rvalid,
    output logic [DATA_W-1:0] sc_rdata,
    input  logic              ap_valid,
    input  logic              ap_write,
    input  logic [ADDR_W-1:0] ap_addr,
    input  logic [DATA_W-1:0] ap_wdata,
    output logic              ap_rvalid,
    output logic [DATA_W-1:0] ap_rdata,
    output logic [NCH-1:0]    irq_to_ap,
    output logic [NCH-1:0]    irq_to_sc
);
    localparam int NPORT = 2;
    localparam int NST   = 2 * NCH;
    localparam int WORDS = NCH * 256;
    localparam int WI    = $clog2(WORDS);

    logic [NPORT-1:0]              p_valid, p_write;
    logic [NPORT-1:0][ADDR_W-1:0]  p_addr;
    logic [NPORT-1:0][DATA_W-1:0]  p_wdata;
    acc_kind_t                     p_kind [NPORT];
    logic [NPORT-1:0]              p_bank;
    logic [NPORT-1:0][2:0]         p_ch;
    logic [NPORT-1:0][WI-1:0]      p_word;

    // port 0 is the controller, port 1 the application processor
    assign p_valid = {ap_valid, sc_valid};
    assign p_write = {ap_write, sc_write};
    assign p_addr  = {ap_addr,  sc_addr};
    assign p_wdata = {ap_wdata, sc_wdata};

    for (genvar g = 0; g < NPORT; g++) begin : g_dec
        mbx_decode #(.ADDR_W(ADDR_W), .NCH(NCH)) i_dec (
            .addr (p_addr[g]),
            .kind (p_kind[g]),
            .bank (p_bank[g]),
            .ch   (p_ch[g]),
            .word (p_word[g])
        );
    end

    logic [NST-1:0][DATA_W-1:0] set_m, clr_m, status;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (p_valid[p] && p_write[p]) begin
                if (p_kind[p] == ACC_SET)
                    set_m[int'(p_bank[p]) * NCH + int'(p_ch[p])] |= p_wdata[p];
                if (p_kind[p] == ACC_CLR)
                    clr_m[int'(p_bank[p]) * NCH + int'(p_ch[p])] |= p_wdata[p];
            end
        end
    end

    mbx_status_bank #(.NST(NST), .DATA_W(DATA_W)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (set_m),
        .clr_m (clr_m),
        .st_q  (status)
    );

    logic [NPORT-1:0]             ram_en;
    logic [NPORT-1:0][DATA_W-1:0] ram_rd;

    always_comb begin
        for (int p = 0; p < NPORT; p++)
            ram_en[p] = p_valid[p] && (p_kind[p] == ACC_PAY);
    end

    mbx_payload_ram #(.WORDS(WORDS), .DATA_W(DATA_W), .NPORT(NPORT)) i_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (p_write),
        .addr  (p_word),
        .wdata (p_wdata),
        .rdata (ram_rd)
    );

    typedef struct packed {
        logic [NPORT-1:0]             rvalid;
        logic [NPORT-1:0]             pay;
        logic [NPORT-1:0][DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (p_valid[p] && !p_write[p]) begin
                rsp_d.rvalid[p] = 1'b1;
                rsp_d.pay[p]    = (p_kind[p] == ACC_PAY);
                if (p_kind[p] == ACC_STAT)
                    rsp_d.rdata[p] = status[int'(p_bank[p]) * NCH + int'(p_ch[p])];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign sc_rvalid = rsp_q.rvalid[0];
    assign ap_rvalid = rsp_q.rvalid[1];
    assign sc_rdata  = rsp_q.pay[0] ? ram_rd[0] : rsp_q.rdata[0];
    assign ap_rdata  = rsp_q.pay[1] ? ram_rd[1] : rsp_q.rdata[1];

    for (genvar c = 0; c < NCH; c++) begin : g_irq
        assign irq_to_ap[c] = |status[c];
        assign irq_to_sc[c] = |status[NCH + c];
    end
endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter int NCH    = 2,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_valid,
    input logic              sc_write,
    input logic [ADDR_W-1:0] sc_addr,
    input logic [DATA_W-1:0] sc_wdata,
    input logic              sc_rvalid,
    input logic [DATA_W-1:0] sc_rdata,
    input logic              ap_valid,
    input logic              ap_write,
    input logic [ADDR_W-1:0] ap_addr,
    input logic [DATA_W-1:0] ap_wdata,
    input logic [NCH-1:0]    irq_to_ap,
    input logic [NCH-1:0]    irq_to_sc
);
    localparam logic [ADDR_W-1:0] SET0 = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] CLR0 = ADDR_W'(16);

    // R7
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !sc_write) |=> sc_rvalid);

    // R7
    no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_valid && !sc_write) |=> !sc_rvalid);

    // R6
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !sc_write && (sc_addr >> 9) == '0 && sc_addr[4:3] != 2'd0) |=> (sc_rdata == '0));

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sc_valid && sc_write) && !(ap_valid && ap_write)) |=> ($stable(irq_to_ap) && $stable(irq_to_sc)));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_write && sc_addr == SET0 && sc_wdata != '0) |=> irq_to_ap[0]);

    // R3
    full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_write && ap_addr == CLR0 && ap_wdata == '1 &&
         !(sc_valid && sc_write && sc_addr == SET0)) |=> !irq_to_ap[0]);
endmodule

bind mbx_doorbell mbx_doorbell_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .sc_valid(sc_valid), .sc_write(sc_write), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
    .sc_rvalid(sc_rvalid), .sc_rdata(sc_rdata),
    .ap_valid(ap_valid), .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
    .irq_to_ap(irq_to_ap), .irq_to_sc(irq_to_sc)
);

// File: tb/test_mbx_doorbell.sv
module test_mbx_doorbell;
    localparam int NCH = 2, AW = 12, DW = 32, WORDS = 512;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic sc_valid, sc_write, ap_valid, ap_write;
    logic [AW-1:0] sc_addr, ap_addr;
    logic [DW-1:0] sc_wdata, ap_wdata, sc_rdata, ap_rdata;
    logic sc_rvalid, ap_rvalid;
    logic [NCH-1:0] irq_to_ap, irq_to_sc;

    mbx_doorbell #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) i_mbx_doorbell (.*);

    int n_run = 0, n_fail = 0;
    string phase = "R1";

    logic [DW-1:0] st_m [2][NCH];
    logic [DW-1:0] mem_m [WORDS];
    bit            mem_ok [WORDS];
    bit            pend_v [2];
    bit            pend_c [2];
    logic [DW-1:0] pend_d [2];
    string         pend_t [2];

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, phase, act, exp);
        end
    endtask

    // 0 none, 1 status, 2 set, 3 clear, 4 payload (map from R2 and R8)
    function automatic int kind_of(logic [AW-1:0] a, output int b, output int c, output int w);
        b = a[8]; c = a[7:5]; w = a[10:2];
        if (a[11]) return (a[1:0] == 0) ? 4 : 0;
        if (a[10:9] != 0 || a[2:0] != 0 || c >= NCH) return 0;
        case (a[4:3])
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic step(bit v0, bit w0, logic [AW-1:0] a0, logic [DW-1:0] d0,
                        bit v1, bit w1, logic [AW-1:0] a1, logic [DW-1:0] d1);
        bit v[2], w[2];
        logic [AW-1:0] a[2];
        logic [DW-1:0] d[2];
        logic [DW-1:0] sm [2][NCH];
        logic [DW-1:0] cm [2][NCH];
        v[0] = v0; w[0] = w0; a[0] = a0; d[0] = d0;
        v[1] = v1; w[1] = w1; a[1] = a1; d[1] = d1;
        for (int p = 0; p < 2; p++) begin
            logic rv;
            logic [DW-1:0] rd;
            rv = p ? ap_rvalid : sc_rvalid;
            rd = p ? ap_rdata : sc_rdata;
            check(rv == pend_v[p], "R7", DW'(rv), DW'(pend_v[p]));
            if (pend_v[p] && pend_c[p]) check(rd === pend_d[p], pend_t[p], rd, pend_d[p]);
        end
        for (int c = 0; c < NCH; c++) begin
            check(irq_to_ap[c] == (st_m[0][c] != 0), "R5", DW'(irq_to_ap[c]), DW'(st_m[0][c] != 0));
            check(irq_to_sc[c] == (st_m[1][c] != 0), "R5", DW'(irq_to_sc[c]), DW'(st_m[1][c] != 0));
        end
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < NCH; c++) begin sm[b][c] = '0; cm[b][c] = '0; end
        for (int p = 0; p < 2; p++) begin
            int k, b, c, wi;
            k = kind_of(a[p], b, c, wi);
            pend_v[p] = v[p] && !w[p];
            pend_c[p] = 1'b1;
            pend_d[p] = '0;
            pend_t[p] = (k == 4) ? "R8" : (k == 1) ? "R7" : "R6";
            if (k == 1) pend_d[p] = st_m[b][c];
            if (k == 4) begin pend_d[p] = mem_m[wi]; pend_c[p] = mem_ok[wi]; end
            if (v[p] && w[p] && k == 2) sm[b][c] |= d[p];
            if (v[p] && w[p] && k == 3) cm[b][c] |= d[p];
        end
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < NCH; c++) st_m[b][c] = (st_m[b][c] & ~cm[b][c]) | sm[b][c];
        for (int p = 1; p >= 0; p--) begin
            int b, c, wi;
            if (v[p] && w[p] && kind_of(a[p], b, c, wi) == 4) begin
                mem_m[wi] = d[p]; mem_ok[wi] = 1'b1;
            end
        end
        sc_valid = v0; sc_write = w0; sc_addr = a0; sc_wdata = d0;
        ap_valid = v1; ap_write = w1; ap_addr = a1; ap_wdata = d1;
        @(negedge clk);
    endtask

    task automatic sc_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        step(1'b1, w, a, d, 1'b0, 1'b0, '0, '0);
    endtask
    task automatic ap_op(bit w, logic [AW-1:0] a, logic [DW-1:0] d);
        step(1'b0, 1'b0, '0, '0, 1'b1, w, a, d);
    endtask
    task automatic idle();
        step(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, '0);
    endtask

    function automatic logic [AW-1:0] rnd_addr();
        int r;
        r = $urandom % 8;
        if (r < 5) return AW'((($urandom % 2) << 8) | (($urandom % 3) << 5) | (($urandom % 4) << 3));
        if (r < 7) return AW'(12'h800 | (((($urandom % 16) * 33) % WORDS) << 2));
        return AW'($urandom);
    endfunction

    function automatic logic [DW-1:0] rnd_data();
        int r;
        r = $urandom % 4;
        if (r == 0) return '1;
        if (r == 1) return DW'(1) << ($urandom % DW);
        return $urandom & $urandom;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < NCH; c++) st_m[b][c] = '0;
        for (int i = 0; i < WORDS; i++) begin mem_m[i] = '0; mem_ok[i] = 1'b0; end
        for (int p = 0; p < 2; p++) begin pend_v[p] = 0; pend_c[p] = 0; pend_d[p] = '0; pend_t[p] = "R7"; end
        rst_n = 1'b0;
        sc_valid = 0; sc_write = 0; sc_addr = '0; sc_wdata = '0;
        ap_valid = 0; ap_write = 0; ap_addr = '0; ap_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs straight after reset, then every status reads zero
        check(irq_to_ap == '0 && irq_to_sc == '0, "R1", DW'({irq_to_ap, irq_to_sc}), '0);
        check(!sc_rvalid && !ap_rvalid, "R1", DW'({sc_rvalid, ap_rvalid}), '0);
        sc_op(0, 12'h000, '0); sc_op(0, 12'h020, '0); ap_op(0, 12'h100, '0); ap_op(0, 12'h120, '0);

        phase = "R2";
        sc_op(1, 12'h028, 32'h5); sc_op(1, 12'h028, 32'hA0); ap_op(0, 12'h020, '0);
        ap_op(1, 12'h108, 32'h1); sc_op(0, 12'h100, '0);

        phase = "R3";
        ap_op(1, 12'h030, 32'h4); ap_op(0, 12'h020, '0);
        ap_op(1, 12'h030, 32'hFFFF_FFFF); ap_op(0, 12'h020, '0);
        sc_op(1, 12'h110, 32'hFFFF_FFFF); idle();

        phase = "R4";
        step(1, 1, 12'h008, 32'hF, 1, 1, 12'h010, 32'hFFFF_FFFF);
        sc_op(0, 12'h000, '0);
        step(1, 1, 12'h128, 32'h30, 1, 1, 12'h128, 32'h3);
        step(1, 1, 12'h130, 32'h11, 1, 1, 12'h128, 32'h10);
        sc_op(0, 12'h120, '0);

        phase = "R6";
        ap_op(1, 12'h000, 32'hFFFF_0000); ap_op(0, 12'h000, '0);
        ap_op(0, 12'h008, '0); ap_op(0, 12'h010, '0); ap_op(0, 12'h0C0, '0); ap_op(0, 12'h018, '0);
        sc_op(1, 12'h048, 32'h1); sc_op(0, 12'h040, '0);

        phase = "R7";
        step(1, 0, 12'h100, '0, 1, 1, 12'h108, 32'h100);
        sc_op(0, 12'h100, '0);

        phase = "R8";
        ap_op(1, 12'hA00, 32'hCAFE_0001); sc_op(0, 12'hA00, '0); ap_op(0, 12'hA00, '0);
        sc_op(1, 12'hC00, 32'h1234_5678); ap_op(0, 12'hC00, '0);
        step(1, 0, 12'hA00, '0, 1, 1, 12'hA00, 32'h0BAD_F00D);
        sc_op(0, 12'hA00, '0);

        phase = "R9";
        step(1, 1, 12'h804, 32'h5C5C_0000, 1, 1, 12'h804, 32'hA9A9_0000);
        ap_op(0, 12'h804, '0); sc_op(0, 12'h804, '0);

        phase = "R10";
        for (int i = 0; i < 3000; i++)
            step($urandom % 4 != 0, $urandom % 2 == 1, rnd_addr(), rnd_data(),
                 $urandom % 4 != 0, $urandom % 2 == 1, rnd_addr(), rnd_data());
        idle(); idle();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule